// File: doc/BRIEF.md
# Differential Encoder Line Fault Monitor

This block watches the three complementary line pairs of an incremental encoder (A, B and the index channel Z) after they have been synchronised to the local clock. It reports two kinds of line fault. A broken or unplugged wire shows up as a line that carries the same level as its partner. A noisy or failing channel shows up as A and B both changing level in the same clock cycle. A properly phased encoder never does this.

Each kind of event is counted over a time window that is measured in ticks of a slow timebase. The error status word shows a live open-wire bit. It also has two latched bits that are raised only when the number of events within one window exceeds a threshold, so a single glitch never trips the feedback-loss logic. Control software reads the two live counters and the status word. It clears the latched bits with a one-cycle clear pulse.

Top module: `enc_fault_monitor`

## Requirements
- R1: `err_status[0]` (open wire) equals, one clock after the inputs are sampled, the OR of (A equal to A-not), (B equal to B-not) and, when enabled, (Z equal to Z-not).
- R2: While `z_enable` is low, a Z pair carrying equal levels neither sets `err_status[0]` nor counts as an event.
- R3: The open-wire event counter `pl_count` advances by one on each cycle where the open-wire condition rises from false to true. It stays constant while the condition persists, and it saturates at 127.
- R4: `err_status[1]` (phase loss) is set, in the cycle the counter is updated, by an open-wire event that leaves `pl_count` above 30. It then stays set until a clear.
- R5: A quadrature event is a cycle in which both A and B differ from their values in the previous cycle. Each event advances `ql_count` by one, saturating at 15. The first cycle after reset is never an event.
- R6: `err_status[2]` (quad loss) is set by a quadrature event that leaves `ql_count` above 10, and it is sticky. While `a_only` is high, no quadrature event is counted.
- R7: Each counter has its own window of PL_WIN_TICKS or QL_WIN_TICKS timebase ticks. On the tick that completes a window, the counter restarts at 1 if an event occurs in that cycle, and at 0 otherwise.
- R8: A cycle with `fault_clr` high leaves `err_status[1]` and `err_status[2]` at 0, even if an event in that cycle would set them. It does not change the counters.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 1 | Channel A, synchronised |
| a_n | input | 1 | Channel A complement |
| b | input | 1 | Channel B |
| b_n | input | 1 | Channel B complement |
| z | input | 1 | Index channel Z |
| z_n | input | 1 | Index channel complement |
| z_enable | input | 1 | Include the Z pair in open-wire checking |
| a_only | input | 1 | Single-channel encoder: disable quadrature checking |
| fault_clr | input | 1 | Clear the latched fault bits |
| tick | input | 1 | Timebase tick, one clock wide |
| err_status | output | 3 | Bit 0 open wire, bit 1 phase loss, bit 2 quad loss |
| pl_count | output | PL_CNT_W (7) | Open-wire events in the current window |
| ql_count | output | QL_CNT_W (4) | Quadrature events in the current window |

## Verification
A stale edge-detection register shows up in the very next cycle. Either `pl_count` fails to advance on a fresh open-wire glitch, or it keeps climbing while a fault persists. A wrong previous A/B sample makes `ql_count` move on single-channel toggles. A window tick counter that is off by one is seen at the window boundary as a counter that restarts one tick early or one tick late. A latch fault in a sticky bit is visible at the first clear, or at the first cycle after the threshold is crossed. The reference model is compared against every output on every clock, so each of these faults is reported within one cycle of when it appears.

// File: rtl/enc_fault_pkg.sv
package enc_fault_pkg;

    localparam int ERR_W      = 3;
    localparam int ERR_OPEN   = 0;
    localparam int ERR_PHASE  = 1;
    localparam int ERR_QUAD   = 2;

    typedef struct packed {
        logic ow;
        logic a;
        logic b;
        logic vld;
    } det_state_t;

endpackage

// File: rtl/enc_line_detect.sv
module enc_line_detect
    import enc_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic a_n,
    input  logic b,
    input  logic b_n,
    input  logic z,
    input  logic z_n,
    input  logic z_enable,
    input  logic a_only,
    output logic ow_live,
    output logic ow_evt,
    output logic quad_evt
);

    det_state_t st_d, st_q;
    logic       ow_now;

    always_comb begin
        ow_now   = (a == a_n) | (b == b_n) | (z_enable & (z == z_n));
        ow_evt   = ow_now & ~st_q.ow;
        quad_evt = st_q.vld & ~a_only & (a ^ st_q.a) & (b ^ st_q.b);
        st_d     = st_q;
        st_d.ow  = ow_now;
        st_d.a   = a;
        st_d.b   = b;
        st_d.vld = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ow_live = st_q.ow;

endmodule

// File: rtl/enc_window_counter.sv
module enc_window_counter #(
    parameter int WIN_TICKS = 8,
    parameter int CNT_W     = 7,
    parameter int THRESH    = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             evt,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    localparam int               TICK_W  = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;
    localparam logic [TICK_W-1:0] T_LAST = TICK_W'(WIN_TICKS - 1);
    localparam logic [CNT_W-1:0]  C_MAX  = '1;
    localparam logic [CNT_W-1:0]  C_THR  = CNT_W'(THRESH);

    typedef struct packed {
        logic [TICK_W-1:0] ticks;
        logic [CNT_W-1:0]  cnt;
        logic              flag;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       boundary;

    always_comb begin
        st_d     = st_q;
        boundary = tick && (st_q.ticks == T_LAST);
        if (boundary) begin
            st_d.ticks = '0;
            st_d.cnt   = evt ? CNT_W'(1) : '0;
        end else begin
            if (tick) st_d.ticks = st_q.ticks + 1'b1;
            if (evt && st_q.cnt != C_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (clr)                          st_d.flag = 1'b0;
        else if (evt && st_d.cnt > C_THR) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign flag = st_q.flag;

endmodule

// File: rtl/enc_fault_monitor.sv
module enc_fault_monitor
    import enc_fault_pkg::*;
#(
    parameter int PL_WIN_TICKS = 8,
    parameter int QL_WIN_TICKS = 10,
    parameter int PL_CNT_W     = 7,
    parameter int QL_CNT_W     = 4,
    parameter int PL_THRESH    = 30,
    parameter int QL_THRESH    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a,
    input  logic                a_n,
    input  logic                b,
    input  logic                b_n,
    input  logic                z,
    input  logic                z_n,
    input  logic                z_enable,
    input  logic                a_only,
    input  logic                fault_clr,
    input  logic                tick,
    output logic [ERR_W-1:0]    err_status,
    output logic [PL_CNT_W-1:0] pl_count,
    output logic [QL_CNT_W-1:0] ql_count
);

    logic ow_live, ow_evt, quad_evt;
    logic pl_flag, ql_flag;

    enc_line_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .a        (a),
        .a_n      (a_n),
        .b        (b),
        .b_n      (b_n),
        .z        (z),
        .z_n      (z_n),
        .z_enable (z_enable),
        .a_only   (a_only),
        .ow_live  (ow_live),
        .ow_evt   (ow_evt),
        .quad_evt (quad_evt)
    );

    enc_window_counter #(
        .WIN_TICKS (PL_WIN_TICKS),
        .CNT_W     (PL_CNT_W),
        .THRESH    (PL_THRESH)
    ) u_pl_win (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .evt   (ow_evt),
        .clr   (fault_clr),
        .cnt   (pl_count),
        .flag  (pl_flag)
    );

    enc_window_counter #(
        .WIN_TICKS (QL_WIN_TICKS),
        .CNT_W     (QL_CNT_W),
        .THRESH    (QL_THRESH)
    ) u_ql_win (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .evt   (quad_evt),
        .clr   (fault_clr),
        .cnt   (ql_count),
        .flag  (ql_flag)
    );

    always_comb begin
        err_status            = '0;
        err_status[ERR_OPEN]  = ow_live;
        err_status[ERR_PHASE] = pl_flag;
        err_status[ERR_QUAD]  = ql_flag;
    end

endmodule

// File: rtl/enc_fault_checker.sv
module enc_fault_checker #(
    parameter int PL_CNT_W  = 7,
    parameter int QL_CNT_W  = 4,
    parameter int PL_THRESH = 30
) (
    input logic                clk,
    input logic                rst_n,
    input logic                a,
    input logic                a_n,
    input logic                b,
    input logic                b_n,
    input logic                z,
    input logic                z_n,
    input logic                z_enable,
    input logic                a_only,
    input logic                fault_clr,
    input logic [2:0]          err_status,
    input logic [PL_CNT_W-1:0] pl_count,
    input logic [QL_CNT_W-1:0] ql_count
);

    localparam logic [PL_CNT_W-1:0] PL_THR = PL_CNT_W'(PL_THRESH);

    a_r1_open_live: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> err_status[0] == ($past(a == a_n) || $past(b == b_n)
                                           || ($past(z_enable) && $past(z == z_n))));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_count > $past(pl_count)) |-> pl_count == PL_CNT_W'($past(pl_count) + 1'b1));

    a_r4_sticky_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_status[1]) && !$past(fault_clr)) |-> err_status[1]);

    a_r4_rise_over_thr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_status[1]) |-> pl_count > PL_THR);

    a_r6_aonly_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(a_only) |-> !(ql_count > $past(ql_count)));

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault_clr) |-> (!err_status[1] && !err_status[2]));

endmodule

bind enc_fault_monitor enc_fault_checker #(
    .PL_CNT_W  (PL_CNT_W),
    .QL_CNT_W  (QL_CNT_W),
    .PL_THRESH (PL_THRESH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a          (a),
    .a_n        (a_n),
    .b          (b),
    .b_n        (b_n),
    .z          (z),
    .z_n        (z_n),
    .z_enable   (z_enable),
    .a_only     (a_only),
    .fault_clr  (fault_clr),
    .err_status (err_status),
    .pl_count   (pl_count),
    .ql_count   (ql_count)
);

// File: tb/enc_fault_monitor_bench.sv
`timescale 1ns/1ps
module enc_fault_monitor_bench;

    localparam int PLW = 4;
    localparam int QLW = 5;
    localparam int PLMAX = 127;
    localparam int QLMAX = 15;
    localparam int PLTH = 30;
    localparam int QLTH = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 0, a_n = 1, b = 0, b_n = 1, z = 0, z_n = 1;
    logic z_enable = 0, a_only = 0, fault_clr = 0, tick = 0;
    logic [2:0] err_status;
    logic [6:0] pl_count;
    logic [3:0] ql_count;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    enc_fault_monitor #(
        .PL_WIN_TICKS (PLW),
        .QL_WIN_TICKS (QLW),
        .PL_CNT_W     (7),
        .QL_CNT_W     (4),
        .PL_THRESH    (PLTH),
        .QL_THRESH    (QLTH)
    ) u_enc_fault_monitor (
        .clk(clk), .rst_n(rst_n), .a(a), .a_n(a_n), .b(b), .b_n(b_n),
        .z(z), .z_n(z_n), .z_enable(z_enable), .a_only(a_only),
        .fault_clr(fault_clr), .tick(tick), .err_status(err_status),
        .pl_count(pl_count), .ql_count(ql_count)
    );

    // behavioural reference model
    int m_ow, m_pa, m_pb, m_vld, m_plt, m_qlt, m_plc, m_qlc, m_plf, m_qlf;

    always @(posedge clk) begin
        int ow, owe, qe;
        if (!rst_n) begin
            m_ow = 0; m_pa = 0; m_pb = 0; m_vld = 0;
            m_plt = 0; m_qlt = 0; m_plc = 0; m_qlc = 0; m_plf = 0; m_qlf = 0;
        end else begin
            ow  = (a == a_n) || (b == b_n) || (z_enable && (z == z_n));
            owe = ow && !m_ow;
            qe  = m_vld && !a_only && (a != m_pa) && (b != m_pb);
            if (tick && m_plt == PLW - 1) begin
                m_plt = 0; m_plc = owe ? 1 : 0;
            end else begin
                if (tick) m_plt++;
                if (owe && m_plc < PLMAX) m_plc++;
            end
            if (tick && m_qlt == QLW - 1) begin
                m_qlt = 0; m_qlc = qe ? 1 : 0;
            end else begin
                if (tick) m_qlt++;
                if (qe && m_qlc < QLMAX) m_qlc++;
            end
            if (fault_clr) begin
                m_plf = 0; m_qlf = 0;
            end else begin
                if (owe && m_plc > PLTH) m_plf = 1;
                if (qe && m_qlc > QLTH) m_qlf = 1;
            end
            m_ow = ow; m_pa = a; m_pb = b; m_vld = 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 open wire bit", int'(err_status[0]), m_ow);
            chk("R4 phase loss bit", int'(err_status[1]), m_plf);
            chk("R6 quad loss bit", int'(err_status[2]), m_qlf);
            chk("R3 pl_count", int'(pl_count), m_plc);
            chk("R5 ql_count", int'(ql_count), m_qlc);
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic ow_pulse();
        a_n = a; cyc();
        a_n = ~a; cyc();
    endtask

    task automatic quad_step();
        a = ~a; a_n = ~a; b = ~b; b_n = ~b; cyc();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; cyc();
            tick = 0; cyc();
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1; cyc();
        // R9: reset state
        chk("R9 err_status", int'(err_status), 0);
        chk("R9 pl_count", int'(pl_count), 0);
        chk("R9 ql_count", int'(ql_count), 0);

        // R3 / R4: threshold crossing
        repeat (30) ow_pulse();
        chk("R4 no flag at 30", int'(err_status[1]), 0);
        chk("R3 count 30", int'(pl_count), 30);
        ow_pulse();
        chk("R4 flag at 31", int'(err_status[1]), 1);
        // R3: a persistent fault counts once
        a_n = a; repeat (5) cyc();
        chk("R3 persist counts once", int'(pl_count), 32);
        chk("R1 open wire live", int'(err_status[0]), 1);
        a_n = ~a; cyc();
        repeat (100) ow_pulse();
        chk("R3 saturate", int'(pl_count), 127);

        // R8: clear wins, counters kept
        fault_clr = 1; cyc(); fault_clr = 0;
        chk("R8 phase cleared", int'(err_status[1]), 0);
        chk("R8 count kept", int'(pl_count), 127);

        // R7: window restart
        ticks(PLW);
        chk("R7 pl window restart", int'(pl_count), 0);

        // R2: Z excluded when disabled
        z_n = z; cyc(); cyc();
        chk("R2 z ignored", int'(err_status[0]), 0);
        chk("R2 z not counted", int'(pl_count), 0);
        z_enable = 1; cyc();
        chk("R2 z enabled", int'(err_status[0]), 1);
        z_n = ~z; z_enable = 0; cyc();

        // R5 / R6: quadrature
        repeat (10) quad_step();
        chk("R6 no quad flag at 10", int'(err_status[2]), 0);
        quad_step();
        chk("R6 quad flag at 11", int'(err_status[2]), 1);
        repeat (10) quad_step();
        chk("R5 ql saturate", int'(ql_count), 15);
        ticks(QLW);
        chk("R7 ql window restart", int'(ql_count), 0);
        a = ~a; a_n = ~a; cyc();
        chk("R5 single channel no event", int'(ql_count), 0);
        a_only = 1;
        repeat (4) quad_step();
        chk("R6 a_only ignores quad", int'(ql_count), 0);
        a_only = 0;

        // mixed random traffic, compared every cycle by the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            a_n = ~a; b_n = ~b; z_n = ~z;
            if (r < 10) a_n = a;
            else if (r < 15) b_n = b;
            else if (r < 20) z_n = z;
            if ($urandom_range(0, 3) == 0) begin a = ~a; a_n = ~a_n; end
            if ($urandom_range(0, 3) == 0) begin b = ~b; b_n = ~b_n; end
            tick      = ($urandom_range(0, 7) == 0);
            fault_clr = ($urandom_range(0, 99) == 0);
            if ($urandom_range(0, 199) == 0) z_enable = ~z_enable;
            if ($urandom_range(0, 199) == 0) a_only = ~a_only;
            cyc();
        end
        tick = 0; fault_clr = 0;
        cyc();
        summary();
    end

endmodule